// File: doc/BRIEF.md
# Pipelined Natural Logarithm Unit

This block returns the natural logarithm of a number slightly above one. The operand arrives as an unsigned fraction `in_frac` with an implied leading one, so the value is x = 1 + in_frac / 2^FRAC_W and lies in [1, 2). The result is an unsigned fraction of the same width: ln(x) scaled by 2^FRAC_W. The unit accepts one operand per clock and returns one result per clock after a fixed latency. A valid bit travels alongside each operand.

The work is split into two parts. The first part is one pipeline stage per iteration k = 1..ITERS. Each stage tests whether scaling a running product y by (1 + 2^-k) keeps y at or below x. When it does, the stage takes the step and adds a hard-wired ln(1 + 2^-k) constant into a log total. That total is held in redundant carry-save form. The second part handles what is left over, x - y. It uses a single first-order integration step, ln(x) ≈ total + (x - y) / y, which needs one division. A narrow restoring divider produces the quotient. Its dividend has both ends cut off, and its divisor is one plus a few fraction bits of y. The divider is spread over DIV_STAGES pipeline stages. A final register adds the carry-save pair and the quotient once and rounds the sum to the output width.

Range reduction and exponent handling are left to the surrounding datapath.

Top module: `ln_shift_add_pipe`

## Requirements
- R1: While `rst` is high, and in the following cycles until an accepted operand has had time to finish, `out_valid` stays low. Operands presented while `rst` is high are discarded.
- R2: An operand accepted at a rising edge with `in_valid` high produces `out_valid` high for exactly one cycle. That cycle begins ITERS + DIV_STAGES + 1 edges after the operand is accepted, counting the accepting edge, which is 14 edges with the defaults.
- R3: `out_ln`, read as an unsigned value scaled by 2^-FRAC_W, differs from ln(1 + in_frac / 2^FRAC_W) by at most 1 unit of its last bit for every input code.
- R4: Input code 0 (x = 1) yields `out_ln` equal to exactly 0.
- R5: For two input codes that are 4 or more apart, the larger code never yields a smaller `out_ln`.
- R6: Operands presented on consecutive cycles with no gaps each return a correct result, one per cycle, in the order they were presented.
- R7: In a cycle where `in_valid` is low, `in_frac` has no effect: that cycle produces no result, and it does not change any other result.
- R8: The all-ones input code yields a result no larger than round(ln 2 · 2^FRAC_W), which is 45426 with the defaults. No result ever exceeds that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears every valid bit in the pipeline |
| in_valid | input | 1 | High when `in_frac` carries an operand to accept at this edge |
| in_frac | input | FRAC_W | Fraction bits of x, with x = 1 + in_frac / 2^FRAC_W |
| out_valid | output | 1 | High for one cycle when `out_ln` holds a result |
| out_ln | output | FRAC_W | ln(x) as an unsigned fraction scaled by 2^FRAC_W |

## Verification
Every result is due exactly 14 rising edges after the edge that accepted its operand, counting that edge. The bench drives inputs on falling edges and records each driven cycle in a ring of history entries. On every falling edge, before it drives the next input, it compares `out_valid` and `out_ln` with the entry written 14 cycles earlier. Because the position of each result is fixed, a bubble, a reset cycle or a dropped operand shows up as a mismatch on the exact cycle where it occurs. Accuracy and ordering are checked on each result against a real-valued logarithm: a full sweep of all input codes, followed by random operands with gaps between them.

// File: rtl/ln_pipe_pkg.sv
`timescale 1ns/1ps
package ln_pipe_pkg;

    // ln(1 + 2^-k) rounded to w fraction bits. It is evaluated as
    // 2*atanh(1/(2^(k+1)+1)) on a 60-bit integer grid; k = 0 gives ln 2.
    function automatic logic [63:0] ln1p_pow2(input int k, input int w);
        logic [63:0] den;
        logic [63:0] den_sq;
        logic [63:0] term;
        logic [63:0] acc;
        den    = (64'd1 << (k + 1)) + 64'd1;
        den_sq = den * den;
        term   = (64'd1 << 60) / den;
        acc    = 64'd0;
        for (int n = 0; n < 40; n++) begin
            acc  = acc + term / 64'(2 * n + 1);
            term = term / den_sq;
        end
        acc = acc << 1;
        return (acc + (64'd1 << (59 - w))) >> (60 - w);
    endfunction

endpackage

// File: rtl/ln_iter_stage.sv
`timescale 1ns/1ps
// One iteration: try y*(1+2^-K) <= x; when the step is taken, add the constant
// into the carry-save log total.
module ln_iter_stage import ln_pipe_pkg::*; #(
    parameter int W = 22,
    parameter int K = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic         v_o,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    localparam logic [W-1:0] KC = W'(ln1p_pow2(K, W));

    logic [W:0]   y_full;
    logic [W:0]   cand;
    logic         take;
    logic [W-1:0] s_n;
    logic [W-1:0] c_n;

    always_comb begin
        y_full = {1'b1, y_i};
        cand   = {1'b0, y_i} + (y_full >> K);
        take   = (cand <= {1'b0, x_i});
        s_n    = s_i ^ c_i ^ KC;
        c_n    = ((s_i & c_i) | (s_i & KC) | (c_i & KC)) << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) v_o <= 1'b0;
        else     v_o <= v_i;
        x_o <= x_i;
        y_o <= take ? cand[W-1:0] : y_i;
        s_o <= take ? s_n : s_i;
        c_o <= take ? c_n : c_i;
    end
endmodule

// File: rtl/ln_div_stage.sv
`timescale 1ns/1ps
// CH steps of restoring radix-2 division. Dividend bits leave the top of nq
// while quotient bits enter at its bottom. The log total rides along.
module ln_div_stage #(
    parameter int W   = 22,
    parameter int DF  = 10,
    parameter int NWP = 24,
    parameter int CH  = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           v_i,
    input  logic [DF:0]    dv_i,
    input  logic [DF+1:0]  rem_i,
    input  logic [NWP-1:0] nq_i,
    input  logic [W-1:0]   s_i,
    input  logic [W-1:0]   c_i,
    output logic           v_o,
    output logic [DF:0]    dv_o,
    output logic [DF+1:0]  rem_o,
    output logic [NWP-1:0] nq_o,
    output logic [W-1:0]   s_o,
    output logic [W-1:0]   c_o
);
    logic [DF+1:0]  r;
    logic [NWP-1:0] q;

    always_comb begin
        r = rem_i;
        q = nq_i;
        for (int i = 0; i < CH; i++) begin
            r = {r[DF:0], q[NWP-1]};
            q = {q[NWP-2:0], 1'b0};
            if (r >= {1'b0, dv_i}) begin
                r    = r - {1'b0, dv_i};
                q[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_o <= 1'b0;
        else     v_o <= v_i;
        dv_o  <= dv_i;
        rem_o <= r;
        nq_o  <= q;
        s_o   <= s_i;
        c_o   <= c_i;
    end
endmodule

// File: rtl/ln_shift_add_pipe.sv
`timescale 1ns/1ps
module ln_shift_add_pipe import ln_pipe_pkg::*; #(
    parameter int FRAC_W     = 16,
    parameter int GUARD      = 6,
    parameter int ITERS      = 11,
    parameter int DIV_FRAC   = 10,
    parameter int DIV_DROP   = 2,
    parameter int DIV_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FRAC_W-1:0] in_frac,
    output logic              out_valid,
    output logic [FRAC_W-1:0] out_ln
);
    localparam int W   = FRAC_W + GUARD;
    localparam int RK  = W - ITERS + 3 - DIV_DROP;     // kept dividend bits
    localparam int NW  = RK + DIV_DROP + DIV_FRAC;     // division steps
    localparam int CH  = (NW + DIV_STAGES - 1) / DIV_STAGES;
    localparam int NWP = CH * DIV_STAGES;
    localparam int RW  = DIV_FRAC + 2;

    // iteration chain
    logic         va [ITERS+1];
    logic [W-1:0] xa [ITERS+1];
    logic [W-1:0] ya [ITERS+1];
    logic [W-1:0] sa [ITERS+1];
    logic [W-1:0] ca [ITERS+1];

    assign va[0] = in_valid;
    assign xa[0] = {in_frac, {GUARD{1'b0}}};
    assign ya[0] = '0;
    assign sa[0] = '0;
    assign ca[0] = '0;

    for (genvar k = 1; k <= ITERS; k++) begin : g_iter
        ln_iter_stage #(.W(W), .K(k)) u_st (
            .clk(clk), .rst(rst),
            .v_i(va[k-1]), .x_i(xa[k-1]), .y_i(ya[k-1]), .s_i(sa[k-1]), .c_i(ca[k-1]),
            .v_o(va[k]),   .x_o(xa[k]),   .y_o(ya[k]),   .s_o(sa[k]),   .c_o(ca[k])
        );
    end

    // truncated operands for the integration division
    logic [W-1:0]      resid;
    logic [RK-1:0]     rt;
    logic [DIV_FRAC:0] dvs;

    assign resid = xa[ITERS] - ya[ITERS];
    assign rt    = RK'(resid >> DIV_DROP);
    assign dvs   = (DIV_FRAC + 1)'({1'b1, ya[ITERS]} >> (W - DIV_FRAC));

    logic              v_d   [DIV_STAGES+1];
    logic [DIV_FRAC:0] dv_a  [DIV_STAGES+1];
    logic [RW-1:0]     rem_a [DIV_STAGES+1];
    logic [NWP-1:0]    nq_a  [DIV_STAGES+1];
    logic [W-1:0]      sd    [DIV_STAGES+1];
    logic [W-1:0]      cd    [DIV_STAGES+1];

    assign v_d[0]   = va[ITERS];
    assign dv_a[0]  = dvs;
    assign rem_a[0] = '0;
    assign nq_a[0]  = NWP'(rt) << (DIV_DROP + DIV_FRAC);
    assign sd[0]    = sa[ITERS];
    assign cd[0]    = ca[ITERS];

    for (genvar j = 0; j < DIV_STAGES; j++) begin : g_div
        ln_div_stage #(.W(W), .DF(DIV_FRAC), .NWP(NWP), .CH(CH)) u_dv (
            .clk(clk), .rst(rst),
            .v_i(v_d[j]), .dv_i(dv_a[j]), .rem_i(rem_a[j]), .nq_i(nq_a[j]),
            .s_i(sd[j]), .c_i(cd[j]),
            .v_o(v_d[j+1]), .dv_o(dv_a[j+1]), .rem_o(rem_a[j+1]), .nq_o(nq_a[j+1]),
            .s_o(sd[j+1]), .c_o(cd[j+1])
        );
    end

    // single carry-propagate add, then round away the guard bits
    logic [W-1:0] total;
    logic [W-1:0] rounded;

    assign total   = sd[DIV_STAGES] + cd[DIV_STAGES] + W'(nq_a[DIV_STAGES]);
    assign rounded = (total + (W'(1) << (GUARD - 1))) >> GUARD;

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= v_d[DIV_STAGES];
        out_ln <= FRAC_W'(rounded);
    end
endmodule

// File: rtl/ln_pipe_chk.sv
`timescale 1ns/1ps
module ln_pipe_chk import ln_pipe_pkg::*; #(
    parameter int FRAC_W     = 16,
    parameter int GUARD      = 6,
    parameter int ITERS      = 11,
    parameter int DIV_FRAC   = 10,
    parameter int DIV_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [FRAC_W-1:0]   in_frac,
    input logic                out_valid,
    input logic [FRAC_W-1:0]   out_ln,
    input logic                tail_valid,
    input logic [FRAC_W+GUARD-1:0] tail_x,
    input logic [FRAC_W+GUARD-1:0] tail_y,
    input logic                div_valid,
    input logic [DIV_FRAC+1:0] div_rem,
    input logic [DIV_FRAC:0]   div_dv
);
    localparam int W = FRAC_W + GUARD;
    localparam int L = ITERS + DIV_STAGES + 1;
    localparam logic [FRAC_W-1:0] LN2_Q = FRAC_W'(ln1p_pow2(0, FRAC_W));

    logic [L-1:0] vh;
    logic [L-1:0] zh;

    always_ff @(posedge clk) begin
        if (rst) begin
            vh <= '0;
            zh <= '0;
        end else begin
            vh <= {vh[L-2:0], in_valid};
            zh <= {zh[L-2:0], in_valid && (in_frac == '0)};
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);

    assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vh[L-1]);

    assert_unit_input_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zh[L-1]) |-> (out_ln == '0));

    assert_below_ln2_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_ln <= LN2_Q));

    assert_product_not_above_R3: assert property (@(posedge clk) disable iff (rst)
        tail_valid |-> (tail_y <= tail_x));

    assert_residual_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        tail_valid |-> (((tail_x - tail_y) >> (W - ITERS + 3)) == '0));

    assert_remainder_bound_R3: assert property (@(posedge clk) disable iff (rst)
        div_valid |-> (div_rem < {1'b0, div_dv}));
endmodule

bind ln_shift_add_pipe ln_pipe_chk #(
    .FRAC_W(FRAC_W), .GUARD(GUARD), .ITERS(ITERS),
    .DIV_FRAC(DIV_FRAC), .DIV_STAGES(DIV_STAGES)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frac(in_frac),
    .out_valid(out_valid), .out_ln(out_ln),
    .tail_valid(va[ITERS]), .tail_x(xa[ITERS]), .tail_y(ya[ITERS]),
    .div_valid(v_d[DIV_STAGES]), .div_rem(rem_a[DIV_STAGES]), .div_dv(dv_a[DIV_STAGES])
);

// File: tb/sim_ln_shift_add_pipe.sv
`timescale 1ns/1ps
module sim_ln_shift_add_pipe;
    localparam int FW  = 16;
    localparam int LAT = 14;
    localparam int LN2_CODE = 45426;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [FW-1:0] in_frac = '0;
    logic          out_valid;
    logic [FW-1:0] out_ln;

    always #2.5 clk = ~clk;

    ln_shift_add_pipe u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_frac(in_frac),
        .out_valid(out_valid), .out_ln(out_ln)
    );

    int      n_chk = 0;
    int      n_err = 0;
    int      m = 0;
    bit      done = 1'b0;
    string   tag = "R1";
    bit      hv [64];
    int      hf [64];
    int      rc [4];
    int      rv [4];

    task automatic chk(input bit ok, input string req, input real act, input real exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0f expected %0f", req, act, exp_v);
        end
    endtask

    // check the result due now, then drive the next cycle's inputs
    task automatic step(input bit v, input int f, input bit r);
        int  idx;
        bit  ev;
        int  f0;
        real ref_v;
        real d;
        int  slot;
        @(negedge clk);
        idx = (m + 64 - LAT) % 64;
        ev  = hv[idx];
        chk(out_valid === ev, tag, real'(out_valid), real'(ev));
        if (ev && out_valid === 1'b1) begin
            f0    = hf[idx];
            ref_v = $ln(1.0 + real'(f0) / 65536.0) * 65536.0;
            d     = real'(out_ln) - ref_v;
            chk(d <= 1.0 && d >= -1.0, "R3", real'(out_ln), ref_v);
            if (f0 == 0)
                chk(out_ln == 0, "R4", real'(out_ln), 0.0);
            if (f0 == 65535)
                chk(int'(out_ln) <= LN2_CODE, "R8", real'(out_ln), real'(LN2_CODE));
            slot = f0 % 4;
            if (rc[slot] == f0 - 4)
                chk(int'(out_ln) >= rv[slot], "R5", real'(out_ln), real'(rv[slot]));
            rc[slot] = f0;
            rv[slot] = int'(out_ln);
        end
        rst      = r;
        in_valid = v;
        in_frac  = FW'(f);
        hv[m % 64] = v && !r;
        hf[m % 64] = f;
        m++;
    endtask

    initial begin
        #(5.0 * 250000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20817);
        for (int i = 0; i < 4; i++) begin
            rc[i] = -100;
            rv[i] = 0;
        end
        repeat (2) @(posedge clk);
        // R1: operands offered during reset are dropped, output stays quiet
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 16'h1234 + i, 1'b1);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, 1'b0);
        // R2: isolated operands arrive exactly LAT edges later; R4 and R8 corners
        tag = "R2";
        step(1'b1, 0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0);
        step(1'b1, 65535, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b1, 1, 1'b0);
        step(1'b1, 32768, 1'b0);
        step(1'b1, 2, 1'b0);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, 1'b0);
        // R6: full back-to-back sweep of every code (also drives R3, R5)
        tag = "R6";
        for (int c = 0; c < 65536; c++) step(1'b1, c, 1'b0);
        // R7: random operands with bubbles carrying garbage data
        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            int rv_v;
            int rf;
            rv_v = int'($urandom % 2);
            rf   = int'($urandom % 65536);
            step(rv_v[0], rf, 1'b0);
        end
        for (int i = 0; i < LAT + 4; i++) step(1'b0, int'($urandom % 65536), 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule